// File: doc/BRIEF.md
# Display RAM Host Address Controller

This block sits between a host command port and a bit-mapped display memory of 132 columns by 65 rows. The memory is held as eight byte-wide pages plus a ninth one-bit indicator page. The host first selects a page and a column with set commands. It then streams bytes in or out. Each byte covers eight vertically stacked rows of one column, and every data access moves the column on by one. The column stops at the last column. It never wraps into the next page.

A second, fully independent read port serves the panel scan. The scan asks for one pixel by row and segment. A segment-direction flag mirrors the segment-to-column mapping, so the panel can be wired in either orientation. Host writes never stall or corrupt the scan read: a scan read that meets a host write to the same bit in the same cycle returns the value held before the write.

Top module: `dram_host_ctrl`

## Requirements
- R1: After reset the page register, the column register and the direction flag are 0, `host_rd_vld` is 0, `host_rd_data` is 0 and `scan_pix` is 0. A write issued straight after reset lands at page 0, column 0.
- R2: Opcode 0 (set page) loads `host_din[3:0]` into the page register when the value is 0 to 8. Values 9 to 15 are ignored and the page is kept. The page never changes by itself.
- R3: Opcode 1 (set column) loads `host_din` into the column register. Values above 131 load 131.
- R4: Opcode 2 (write) stores `host_din` at the current page and column, then advances the column by one.
- R5: Opcode 3 (read) returns the byte at the current page and column on `host_rd_data`, with `host_rd_vld` high for one cycle, in the cycle after the strobe. It then advances the column by one. Otherwise `host_rd_vld` is low and `host_rd_data` holds its last value.
- R6: A write or read at column 131 leaves the column at 131 and the page unchanged.
- R7: On page 8 only bit 0 of a written byte is kept, and reads return bits 7..1 as 0.
- R8: The scan pixel for row r (0..64) and segment s is bit r mod 8 of page r div 8 at the mapped column. It appears on `scan_pix` one cycle after `scan_row` and `scan_seg` are presented. A row above 64 or a segment above 131 gives 0.
- R9: Opcode 4 (set direction) loads `host_din[0]` into the direction flag. With the flag at 0, segment s reads column s. With the flag at 1, segment s reads column 131 - s.
- R10: A scan read of a bit in the same cycle as a host write to that bit returns the old value. The new value is seen from the following cycle.
- R11: Opcodes 5, 6 and 7 change neither the page, the column, the direction flag nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | Host command strobe, one command per cycle |
| host_op | input | 3 | Command opcode (0 page, 1 column, 2 write, 3 read, 4 direction) |
| host_din | input | 8 | Command argument or write data |
| host_rd_data | output | 8 | Read data |
| host_rd_vld | output | 1 | Read data valid, one cycle |
| scan_row | input | 7 | Scan row, 0 to 64 |
| scan_seg | input | 8 | Scan segment, 0 to 131 |
| scan_pix | output | 1 | Scanned pixel, one cycle after the address |

## Verification
The bench builds the block with its default parameters: 132 columns, eight full pages and one indicator page, and mirroring enabled. At these sizes the column stop at 131, the clamping of oversized column arguments and the one-bit indicator page are each a handful of commands away. Clearing the whole memory through the host port takes only about twelve hundred cycles, so every scanned bit has a known value. Both direction settings and the off-grid scan addresses 65 and 132 can then be tried against a full model of the memory.

// File: rtl/dram_pkg.sv
package dram_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SET_PAGE = 3'd0,
        OP_SET_COL  = 3'd1,
        OP_WRITE    = 3'd2,
        OP_READ     = 3'd3,
        OP_SET_DIR  = 3'd4
    } host_op_e;
endpackage

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl #(
    parameter int NUM_COLS       = 132,
    parameter int NUM_FULL_PAGES = 8,
    parameter int DATA_W         = 8,
    localparam int COL_W  = $clog2(NUM_COLS),
    localparam int PAGE_W = $clog2(NUM_FULL_PAGES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_stb,
    input  logic [dram_pkg::OP_W-1:0] host_op,
    input  logic [DATA_W-1:0]         host_din,
    output logic [PAGE_W-1:0]         page_o,
    output logic [COL_W-1:0]          col_o,
    output logic                      mirror_o,
    output logic                      wr_en_o,
    output logic                      rd_en_o
);
    import dram_pkg::*;

    localparam int MAX_COL  = NUM_COLS - 1;
    localparam int IND_PAGE = NUM_FULL_PAGES;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic              mirror;
    } ctrl_t;

    ctrl_t state_d, state_q;
    logic  wr_en_d, rd_en_d;
    logic  col_at_end;

    assign col_at_end = (state_q.col == COL_W'(MAX_COL));

    always_comb begin
        state_d = state_q;
        wr_en_d = 1'b0;
        rd_en_d = 1'b0;
        if (host_stb) begin
            case (host_op)
                OP_SET_PAGE: begin
                    if (host_din[PAGE_W-1:0] <= PAGE_W'(IND_PAGE))
                        state_d.page = host_din[PAGE_W-1:0];
                end
                OP_SET_COL: begin
                    if (host_din > DATA_W'(MAX_COL))
                        state_d.col = COL_W'(MAX_COL);
                    else
                        state_d.col = host_din[COL_W-1:0];
                end
                OP_WRITE, OP_READ: begin
                    wr_en_d = (host_op == OP_WRITE);
                    rd_en_d = (host_op == OP_READ);
                    if (!col_at_end)
                        state_d.col = state_q.col + 1'b1;
                end
                OP_SET_DIR: state_d.mirror = host_din[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign page_o   = state_q.page;
    assign col_o    = state_q.col;
    assign mirror_o = state_q.mirror;
    assign wr_en_o  = wr_en_d;
    assign rd_en_o  = rd_en_d;

    a_r2_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.page <= PAGE_W'(IND_PAGE));

    a_r2_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_stb && host_op == OP_SET_PAGE) |=> $stable(state_q.page));

    a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.col <= COL_W'(MAX_COL));

    a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && (host_op == OP_WRITE || host_op == OP_READ) && state_q.col != COL_W'(MAX_COL))
        |=> state_q.col == $past(state_q.col) + 1'b1);

    a_r6_col_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && (host_op == OP_WRITE || host_op == OP_READ) && state_q.col == COL_W'(MAX_COL))
        |=> (state_q.col == COL_W'(MAX_COL)) && $stable(state_q.page));

    a_r11_unused_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && host_op > OP_SET_DIR) |=> $stable(state_q));
endmodule

// File: rtl/dram_scan_map.sv
module dram_scan_map #(
    parameter int NUM_COLS       = 132,
    parameter int NUM_FULL_PAGES = 8,
    parameter int DATA_W         = 8,
    parameter bit MIRROR_EN      = 1'b1,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int PAGE_W   = $clog2(NUM_FULL_PAGES + 1),
    localparam int NUM_ROWS = NUM_FULL_PAGES * DATA_W + 1,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mirror,
    input  logic [ROW_W-1:0]  scan_row,
    input  logic [COL_W-1:0]  scan_seg,
    input  logic [DATA_W-1:0] scan_byte,
    output logic [PAGE_W-1:0] s_page_o,
    output logic [COL_W-1:0]  s_col_o,
    output logic              s_en_o,
    output logic              scan_pix_o
);
    localparam int MAX_COL = NUM_COLS - 1;

    typedef struct packed {
        logic [BIT_W-1:0] bit_sel;
    } map_t;

    map_t             map_d, map_q;
    logic             on_grid;
    logic [COL_W-1:0] mapped_col;

    assign on_grid = (scan_row < ROW_W'(NUM_ROWS)) && (scan_seg < COL_W'(NUM_COLS));

    generate
        if (MIRROR_EN) begin : g_mirror
            assign mapped_col = mirror ? (COL_W'(MAX_COL) - scan_seg) : scan_seg;
        end else begin : g_straight
            assign mapped_col = scan_seg;
        end
    endgenerate

    always_comb begin
        map_d         = map_q;
        map_d.bit_sel = scan_row[BIT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign s_en_o     = on_grid;
    assign s_page_o   = on_grid ? PAGE_W'(scan_row >> BIT_W) : '0;
    assign s_col_o    = on_grid ? mapped_col : '0;
    assign scan_pix_o = scan_byte[map_q.bit_sel];

    a_r8_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_page_o <= PAGE_W'(NUM_FULL_PAGES));

    a_r9_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_col_o <= COL_W'(MAX_COL));
endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int NUM_COLS       = 132,
    parameter int NUM_FULL_PAGES = 8,
    parameter int DATA_W         = 8,
    localparam int COL_W     = $clog2(NUM_COLS),
    localparam int PAGE_W    = $clog2(NUM_FULL_PAGES + 1),
    localparam int NUM_PAGES = NUM_FULL_PAGES + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PAGE_W-1:0] h_page,
    input  logic [COL_W-1:0]  h_col,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] h_rd_data_o,
    output logic              h_rd_vld_o,
    input  logic              s_en,
    input  logic [PAGE_W-1:0] s_page,
    input  logic [COL_W-1:0]  s_col,
    output logic [DATA_W-1:0] s_byte_o
);
    typedef struct packed {
        logic [DATA_W-1:0] h_data;
        logic              h_vld;
        logic [DATA_W-1:0] s_byte;
    } port_t;

    port_t             port_d, port_q;
    logic [DATA_W-1:0] h_bus [NUM_PAGES];
    logic [DATA_W-1:0] s_bus [NUM_PAGES];

    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_bank
            localparam int W = (p < NUM_FULL_PAGES) ? DATA_W : 1;
            logic [W-1:0] cells [NUM_COLS];

            always_ff @(posedge clk) begin
                if (wr_en && h_page == PAGE_W'(p))
                    cells[h_col] <= wr_data[W-1:0];
            end

            assign h_bus[p] = DATA_W'(cells[h_col]);
            assign s_bus[p] = DATA_W'(cells[s_col]);
        end
    endgenerate

    always_comb begin
        port_d        = port_q;
        port_d.h_vld  = rd_en;
        if (rd_en)
            port_d.h_data = h_bus[h_page];
        port_d.s_byte = s_en ? s_bus[s_page] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign h_rd_data_o = port_q.h_data;
    assign h_rd_vld_o  = port_q.h_vld;
    assign s_byte_o    = port_q.s_byte;

    a_r5_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> h_rd_vld_o);

    a_r5_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !h_rd_vld_o);

    a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(h_rd_data_o));

    a_r7_indicator_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && h_page == PAGE_W'(NUM_FULL_PAGES)) |=> h_rd_data_o[DATA_W-1:1] == '0);
endmodule

// File: rtl/dram_host_ctrl.sv
module dram_host_ctrl #(
    parameter int NUM_COLS       = 132,
    parameter int NUM_FULL_PAGES = 8,
    parameter int DATA_W         = 8,
    parameter bit MIRROR_EN      = 1'b1,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int NUM_ROWS = NUM_FULL_PAGES * DATA_W + 1,
    localparam int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_stb,
    input  logic [dram_pkg::OP_W-1:0] host_op,
    input  logic [DATA_W-1:0]         host_din,
    output logic [DATA_W-1:0]         host_rd_data,
    output logic                      host_rd_vld,
    input  logic [ROW_W-1:0]          scan_row,
    input  logic [COL_W-1:0]          scan_seg,
    output logic                      scan_pix
);
    localparam int PAGE_W = $clog2(NUM_FULL_PAGES + 1);

    logic [PAGE_W-1:0] h_page, s_page;
    logic [COL_W-1:0]  h_col, s_col;
    logic              mirror, wr_en, rd_en, s_en;
    logic [DATA_W-1:0] s_byte;

    dram_addr_ctrl #(
        .NUM_COLS(NUM_COLS), .NUM_FULL_PAGES(NUM_FULL_PAGES), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_stb(host_stb), .host_op(host_op), .host_din(host_din),
        .page_o(h_page), .col_o(h_col), .mirror_o(mirror),
        .wr_en_o(wr_en), .rd_en_o(rd_en)
    );

    dram_scan_map #(
        .NUM_COLS(NUM_COLS), .NUM_FULL_PAGES(NUM_FULL_PAGES), .DATA_W(DATA_W),
        .MIRROR_EN(MIRROR_EN)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .mirror(mirror),
        .scan_row(scan_row), .scan_seg(scan_seg), .scan_byte(s_byte),
        .s_page_o(s_page), .s_col_o(s_col), .s_en_o(s_en), .scan_pix_o(scan_pix)
    );

    dram_store #(
        .NUM_COLS(NUM_COLS), .NUM_FULL_PAGES(NUM_FULL_PAGES), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .h_page(h_page), .h_col(h_col),
        .wr_data(host_din), .h_rd_data_o(host_rd_data), .h_rd_vld_o(host_rd_vld),
        .s_en(s_en), .s_page(s_page), .s_col(s_col), .s_byte_o(s_byte)
    );

    a_r8_offgrid_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_row >= ROW_W'(NUM_ROWS) || scan_seg >= COL_W'(NUM_COLS)) |=> !scan_pix);
endmodule

// File: tb/dram_host_ctrl_tb.sv
module dram_host_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_stb = 1'b0;
    logic [2:0] host_op = 3'd0;
    logic [7:0] host_din = 8'd0;
    logic [7:0] host_rd_data;
    logic       host_rd_vld;
    logic [6:0] scan_row = 7'd0;
    logic [7:0] scan_seg = 8'd0;
    logic       scan_pix;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mdl [9][132];
    int mpage = 0, mcol = 0;
    bit madc = 1'b0;

    always #5 clk = ~clk;

    dram_host_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_stb(host_stb), .host_op(host_op), .host_din(host_din),
        .host_rd_data(host_rd_data), .host_rd_vld(host_rd_vld),
        .scan_row(scan_row), .scan_seg(scan_seg), .scan_pix(scan_pix)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic void adv();
        if (mcol < 131) mcol++;
    endfunction

    task automatic cmd(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        host_stb = 1'b1; host_op = op; host_din = d;
        @(negedge clk);
        host_stb = 1'b0;
    endtask

    task automatic set_page(input int p);
        cmd(3'd0, 8'(p));
        if (p <= 8) mpage = p;
    endtask

    task automatic set_col(input int c);
        cmd(3'd1, 8'(c));
        mcol = (c > 131) ? 131 : c;
    endtask

    task automatic set_dir(input bit m);
        cmd(3'd4, {7'd0, m});
        madc = m;
    endtask

    task automatic wr(input logic [7:0] d);
        cmd(3'd2, d);
        mdl[mpage][mcol] = (mpage == 8) ? {7'd0, d[0]} : d;
        adv();
    endtask

    task automatic rd(input string req);
        cmd(3'd3, 8'd0);
        check({req, " valid"}, host_rd_vld, 1);
        check(req, host_rd_data, mdl[mpage][mcol]);
        adv();
    endtask

    function automatic int exp_pix(input int row, input int seg);
        int col;
        if (row > 64 || seg > 131) return 0;
        col = madc ? 131 - seg : seg;
        return int'(mdl[row / 8][col][row % 8]);
    endfunction

    task automatic scan(input string req, input int row, input int seg);
        @(negedge clk);
        scan_row = 7'(row); scan_seg = 8'(seg);
        @(negedge clk);
        check(req, scan_pix, exp_pix(row, seg));
    endtask

    task automatic t_reset();
        check("R1 rd_vld", host_rd_vld, 0);
        check("R1 rd_data", host_rd_data, 0);
        check("R1 scan_pix", scan_pix, 0);
        wr(8'hA5);
        set_page(0); set_col(0);
        rd("R1 write after reset at page 0 col 0");
    endtask

    task automatic t_clear();
        for (int p = 0; p < 9; p++) begin
            set_page(p); set_col(0);
            for (int c = 0; c < 132; c++) wr(8'h00);
        end
        set_page(0); set_col(0);
        rd("R4 cleared byte");
    endtask

    task automatic t_stream();
        set_page(2); set_col(10);
        for (int i = 0; i < 5; i++) wr(8'(8'h31 + 8'(i * 17)));
        set_col(10);
        for (int i = 0; i < 5; i++) rd("R4 R5 streamed byte");
        @(negedge clk);
        check("R5 vld low when idle", host_rd_vld, 0);
        check("R5 data held", host_rd_data, mdl[2][14]);
    endtask

    task automatic t_saturate();
        set_page(3); set_col(130);
        wr(8'h0A); wr(8'h0B); wr(8'h0C);
        rd("R6 stuck at last column");
        set_col(130);
        rd("R6 column 130"); rd("R6 column 131"); rd("R6 column 131 again");
        set_page(4); set_col(0);
        rd("R6 next page untouched");
    endtask

    task automatic t_col_clamp();
        set_page(3); set_col(200);
        wr(8'h3C);
        set_col(131);
        rd("R3 oversized column clamps to 131");
    endtask

    task automatic t_page_ignore();
        set_page(5); set_col(7);
        set_page(12);
        wr(8'h77);
        set_page(5); set_col(7);
        rd("R2 page code 12 ignored");
        set_page(15); set_col(7);
        rd("R2 page code 15 ignored");
    endtask

    task automatic t_indicator();
        set_page(8); set_col(3);
        wr(8'hFE); wr(8'hFF);
        set_col(3);
        rd("R7 indicator bit0 clear"); rd("R7 indicator upper bits zero");
    endtask

    task automatic t_scan();
        set_page(1); set_col(5); wr(8'h5A);
        set_page(8); set_col(5); wr(8'h01);
        set_dir(1'b0);
        for (int r = 8; r < 16; r++) scan("R8 R9 direct mapping", r, 5);
        scan("R8 indicator row", 64, 5);
        set_dir(1'b1);
        for (int r = 8; r < 16; r++) scan("R9 mirrored mapping", r, 126);
        scan("R9 mirrored indicator", 64, 126);
        scan("R9 mirrored segment 5 reads column 126", 9, 5);
        scan("R8 row 65 off grid", 65, 5);
        scan("R8 segment 132 off grid", 9, 132);
        set_dir(1'b0);
    endtask

    task automatic t_collide();
        set_page(1); set_col(5);
        @(negedge clk);
        host_stb = 1'b1; host_op = 3'd2; host_din = 8'hA5;
        scan_row = 7'd9; scan_seg = 8'd5;
        @(negedge clk);
        host_stb = 1'b0;
        check("R10 old bit during write", scan_pix, int'(mdl[1][5][1]));
        mdl[1][5] = 8'hA5; adv();
        @(negedge clk);
        check("R10 new bit next cycle", scan_pix, 0);
        scan("R10 new bit row 8", 8, 5);
    endtask

    task automatic t_unused();
        set_page(6); set_col(20);
        wr(8'h11);
        for (int op = 5; op < 8; op++) cmd(3'(op), 8'h01);
        wr(8'h22);
        set_col(21);
        rd("R11 column kept after unused opcodes");
        rd("R11 memory untouched");
        scan("R11 direction kept", 48, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clear();
        t_stream();
        t_saturate();
        t_col_clamp();
        t_page_ignore();
        t_indicator();
        t_scan();
        t_collide();
        t_unused();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule